// File: doc/BRIEF.md
# Multichannel Run-Down Conversion Counter

This block is the digital half of a twelve-channel integrating converter that uses the run-down method. Each analog channel stores its input as charge. After a short hold, the charge is drained at a constant rate. A comparator stays active while charge remains. The block turns the length of that drain into a number by counting clock cycles. All channels share one sampling gate and one fast-clear line. The block sequences the cycle: sample, hold, count window, then latch. When the window closes, it freezes all counts into result registers and pulses an end-of-conversion strobe.

Control logic decides after the gate whether an event is worth keeping. The fast-clear input lets it abort a cycle at any point. After an abort, gates are locked out for a settling period, so the analog front end can recover before the next sample. A software test request can generate a short internal gate in place of the external one. The resulting conversion then measures the residual pedestal. Results stay frozen, and further gates are ignored, until a normal clear or a fast clear.

Top module: `rundown_conv_ctrl`

## Requirements
- R1: After reset, `res_valid`, `eoc` and `busy` are 0 and every result field reads 0.
- R2: In the idle state, a high effective gate (external `gate_in`, or the internal test gate) starts a conversion, and `busy` reads 1 after the next clock edge. When the gate is seen low, a hold interval of HOLD_CYC edges follows. Comparator inputs are ignored during the gate and during the hold.
- R3: After the hold, a window of RUN_CYC edges follows. At each of these edges, a channel's counter adds one if its `cmp_in` bit is 1. Channel i's result is `res_flat[i*CNT_W +: CNT_W]`.
- R4: A channel counter stops at 2^CNT_W-1 and does not wrap, however long its comparator stays active.
- R5: `eoc` is a single-cycle pulse. It is seen after the (HOLD_CYC+RUN_CYC+1)-th edge, counting the first edge that samples the gate low as the first. `res_valid` rises in the same cycle.
- R6: While `res_valid` is 1, the result fields do not change. External gates and test requests start nothing and produce no `eoc`.
- R7: A `clr_in` pulse clears `res_valid` and every result field to 0 and returns the block to idle.
- R8: A `fclr_in` pulse in any state aborts the cycle. After the next edge, `res_valid`, `busy` and all result fields are 0, and the aborted cycle never raises `eoc`.
- R9: For SETTLE_CYC edges after a fast clear, gates are ignored. A gate first seen at the edge after that period starts a conversion.
- R10: A `test_req` pulse in idle creates an internal gate lasting TEST_GATE_CYC edges. For that conversion, `eoc` is seen after edge TEST_GATE_CYC+HOLD_CYC+RUN_CYC+1, counting the request edge as edge 0.
- R11: When `fclr_in` and `clr_in` arrive together, the fast clear wins and the settling lockout applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_in | input | 1 | Common external sampling gate, level sensitive |
| test_req | input | 1 | One-cycle request for an internal pedestal gate |
| fclr_in | input | 1 | Fast clear: aborts the cycle and starts the settling lockout |
| clr_in | input | 1 | Normal clear of results and valid flag |
| cmp_in | input | NCH | Per-channel discharge comparator, 1 while charge remains |
| res_flat | output | NCH*CNT_W | Latched counts, channel i at bits i*CNT_W upward |
| res_valid | output | 1 | Results hold a completed conversion |
| eoc | output | 1 | One-cycle end-of-conversion strobe |
| busy | output | 1 | Conversion in progress (sample, hold or window) |

## Verification
The main counting function is driven with random run-down lengths per channel, spread across the full window. This shows that each channel counts independently and lands in its own field. Other runs inject random comparator activity during the gate and the hold. These separate a design that counts only in the window from one that starts counting at the gate. Directed lengths of zero, full scale minus one, full scale and the whole window show the edge between an exact count and saturation. Fast clears placed in the hold and mid-window, and gates placed inside the lockout and just after it, test abort handling and the exact end of the settling period.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SAMPLE = 3'd1,
    ST_HOLD   = 3'd2,
    ST_RUN    = 3'd3,
    ST_DONE   = 3'd4,
    ST_SETTLE = 3'd5
  } rdc_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rdc_test_gate.sv
module rdc_test_gate #(
  parameter int TEST_GATE_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic idle,
  input  logic abort,
  output logic tg_act
);
  localparam int TW = $clog2(TEST_GATE_CYC + 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      tg_act <= 1'b0;
      remain <= '0;
    end else if (!tg_act && req && idle) begin
      tg_act <= 1'b1;
      remain <= TW'(TEST_GATE_CYC);
    end else if (tg_act) begin
      if (remain == TW'(1)) tg_act <= 1'b0;
      remain <= remain - TW'(1);
    end
  end

endmodule

// File: rtl/rdc_seq.sv
module rdc_seq
  import rdc_pkg::*;
#(
  parameter int HOLD_CYC   = 50,
  parameter int RUN_CYC    = 1040,
  parameter int SETTLE_CYC = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gate_eff,
  input  logic       fclr,
  input  logic       clr,
  output rdc_state_e state,
  output logic       cnt_en,
  output logic       cnt_zero,
  output logic       latch,
  output logic       res_clr,
  output logic       eoc,
  output logic       res_valid,
  output logic       busy
);
  localparam int TMAX = max3(HOLD_CYC, RUN_CYC, SETTLE_CYC);
  localparam int TW   = $clog2(TMAX + 1);

  rdc_state_e    state_nxt;
  logic [TW-1:0] tmr;
  logic          hold_last, run_last, settle_last;

  assign hold_last   = (tmr == TW'(HOLD_CYC - 1));
  assign run_last    = (tmr == TW'(RUN_CYC - 1));
  assign settle_last = (tmr == TW'(SETTLE_CYC - 1));

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:   if (gate_eff)    state_nxt = ST_SAMPLE;
      ST_SAMPLE: if (!gate_eff)   state_nxt = ST_HOLD;
      ST_HOLD:   if (hold_last)   state_nxt = ST_RUN;
      ST_RUN:    if (run_last)    state_nxt = ST_DONE;
      ST_DONE:                    state_nxt = ST_DONE;
      ST_SETTLE: if (settle_last) state_nxt = ST_IDLE;
      default:                    state_nxt = ST_IDLE;
    endcase
    if (clr && state != ST_SETTLE) state_nxt = ST_IDLE;
    if (fclr)                      state_nxt = ST_SETTLE;
  end

  assign cnt_en   = (state == ST_RUN) && !fclr && !clr;
  assign latch    = (state == ST_RUN) && run_last && !fclr && !clr;
  assign res_clr  = fclr || clr;
  assign cnt_zero = fclr || clr || (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tmr       <= '0;
      eoc       <= 1'b0;
      res_valid <= 1'b0;
      busy      <= 1'b0;
    end else begin
      state <= state_nxt;
      if (fclr || state_nxt != state) tmr <= '0;
      else                            tmr <= tmr + TW'(1);
      eoc <= latch;
      if (res_clr)    res_valid <= 1'b0;
      else if (latch) res_valid <= 1'b1;
      busy <= (state_nxt == ST_SAMPLE) || (state_nxt == ST_HOLD) ||
              (state_nxt == ST_RUN);
    end
  end

endmodule

// File: rtl/rdc_chan.sv
module rdc_chan #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero,
  input  logic             en,
  input  logic             cmp,
  input  logic             latch,
  input  logic             res_clr,
  output logic [CNT_W-1:0] res
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (en && cmp && cnt != FULL) cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || zero) cnt <= '0;
    else             cnt <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || res_clr) res <= '0;
    else if (latch)     res <= cnt_nxt;
  end

endmodule

// File: rtl/rundown_conv_ctrl.sv
module rundown_conv_ctrl
  import rdc_pkg::*;
#(
  parameter int NCH           = 12,
  parameter int CNT_W         = 10,
  parameter int HOLD_CYC      = 50,
  parameter int RUN_CYC       = (1 << CNT_W) + 16,
  parameter int SETTLE_CYC    = 500,
  parameter int TEST_GATE_CYC = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gate_in,
  input  logic                 test_req,
  input  logic                 fclr_in,
  input  logic                 clr_in,
  input  logic [NCH-1:0]       cmp_in,
  output logic [NCH*CNT_W-1:0] res_flat,
  output logic                 res_valid,
  output logic                 eoc,
  output logic                 busy
);
  rdc_state_e state;
  logic tg_act, gate_eff;
  logic cnt_en, cnt_zero, latch, res_clr;

  assign gate_eff = gate_in || tg_act;

  rdc_test_gate #(.TEST_GATE_CYC(TEST_GATE_CYC)) u_tgate (
    .clk    (clk),
    .rst    (rst),
    .req    (test_req),
    .idle   (state == ST_IDLE),
    .abort  (fclr_in),
    .tg_act (tg_act)
  );

  rdc_seq #(
    .HOLD_CYC   (HOLD_CYC),
    .RUN_CYC    (RUN_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .gate_eff  (gate_eff),
    .fclr      (fclr_in),
    .clr       (clr_in),
    .state     (state),
    .cnt_en    (cnt_en),
    .cnt_zero  (cnt_zero),
    .latch     (latch),
    .res_clr   (res_clr),
    .eoc       (eoc),
    .res_valid (res_valid),
    .busy      (busy)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    rdc_chan #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .zero    (cnt_zero),
      .en      (cnt_en),
      .cmp     (cmp_in[gi]),
      .latch   (latch),
      .res_clr (res_clr),
      .res     (res_flat[gi*CNT_W +: CNT_W])
    );
  end

endmodule

// File: rtl/rundown_conv_ctrl_chk.sv
module rundown_conv_ctrl_chk #(
  parameter int NCH        = 12,
  parameter int CNT_W      = 10,
  parameter int SETTLE_CYC = 500
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 fclr_in,
  input logic                 clr_in,
  input logic [NCH*CNT_W-1:0] res_flat,
  input logic                 res_valid,
  input logic                 eoc,
  input logic                 busy
);
  localparam int LW = $clog2(SETTLE_CYC + 1);
  logic [LW-1:0] lock_cnt;

  always_ff @(posedge clk) begin
    if (rst)               lock_cnt <= '0;
    else if (fclr_in)      lock_cnt <= LW'(SETTLE_CYC);
    else if (lock_cnt != 0) lock_cnt <= lock_cnt - LW'(1);
  end

  a_r5_eoc_single: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc);
  a_r5_eoc_valid: assert property (@(posedge clk) disable iff (rst)
    eoc |-> res_valid);
  a_r5_valid_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> eoc);
  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !fclr_in && !clr_in) |=> $stable(res_flat));
  a_r7_clr: assert property (@(posedge clk) disable iff (rst)
    clr_in |=> (!res_valid && res_flat == '0));
  a_r8_fclr: assert property (@(posedge clk) disable iff (rst)
    fclr_in |=> (!res_valid && !busy && !eoc && res_flat == '0));
  a_r9_lockout: assert property (@(posedge clk) disable iff (rst)
    (lock_cnt != 0) |-> !busy);

endmodule

bind rundown_conv_ctrl rundown_conv_ctrl_chk #(
  .NCH        (NCH),
  .CNT_W      (CNT_W),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fclr_in   (fclr_in),
  .clr_in    (clr_in),
  .res_flat  (res_flat),
  .res_valid (res_valid),
  .eoc       (eoc),
  .busy      (busy)
);

// File: tb/rundown_conv_ctrl_tb.sv
`timescale 1ns/1ps
module rundown_conv_ctrl_tb;
  localparam int NCH    = 12;
  localparam int W      = 10;
  localparam int HOLD   = 50;
  localparam int RUN    = (1 << W) + 16;
  localparam int SETTLE = 500;
  localparam int TG     = 20;
  localparam int MAXV   = (1 << W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic gate_in = 1'b0, test_req = 1'b0, fclr_in = 1'b0, clr_in = 1'b0;
  logic [NCH-1:0]   cmp_in = '0;
  logic [NCH*W-1:0] res_flat;
  logic res_valid, eoc, busy;

  int n_chk = 0, n_fail = 0, eoc_seen = 0;
  int lens[NCH];
  bit finished = 1'b0;

  rundown_conv_ctrl #(
    .NCH(NCH), .CNT_W(W), .HOLD_CYC(HOLD), .RUN_CYC(RUN),
    .SETTLE_CYC(SETTLE), .TEST_GATE_CYC(TG)
  ) u_dut (
    .clk(clk), .rst(rst), .gate_in(gate_in), .test_req(test_req),
    .fclr_in(fclr_in), .clr_in(clr_in), .cmp_in(cmp_in),
    .res_flat(res_flat), .res_valid(res_valid), .eoc(eoc), .busy(busy)
  );

  always #2 clk = ~clk;

  always @(negedge clk) if (!rst && eoc) eoc_seen++;

  function automatic int expect_cnt(input int l);
    int m = l;
    if (m > RUN)  m = RUN;
    if (m > MAXV) m = MAXV;
    return m;
  endfunction

  function automatic int res_of(input int i);
    return int'(res_flat[i*W +: W]);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_results(input string tag, input bit zero);
    for (int i = 0; i < NCH; i++) begin
      int e = zero ? 0 : expect_cnt(lens[i]);
      chk(res_of(i) == e, tag, res_of(i), e);
    end
  endtask

  // Caller is just past a negedge. Gate high for glen edges, then hold and window.
  task automatic run_conv(input bit noise, input int abort_at, input int glen);
    int base;
    gate_in = 1'b1;
    cmp_in  = noise ? NCH'($urandom) : '0;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after gate", busy, 1);
    for (int g = 1; g < glen; g++) begin
      cmp_in = noise ? NCH'($urandom) : '0;
      @(negedge clk);
    end
    gate_in = 1'b0;
    base = eoc_seen;
    for (int j = 0; j <= HOLD + RUN; j++) begin
      for (int i = 0; i < NCH; i++) begin
        if (j >= HOLD + 1) cmp_in[i] = ((j - HOLD - 1) < lens[i]);
        else               cmp_in[i] = noise ? 1'($urandom) : 1'b0;
      end
      fclr_in = (j == abort_at);
      @(negedge clk);
      fclr_in = 1'b0;
      if (j == abort_at) begin
        cmp_in = '0;
        chk(res_valid == 1'b0, "R8 valid after fast clear", res_valid, 0);
        chk(busy == 1'b0, "R8 busy after fast clear", busy, 0);
        check_results("R8 results zero after fast clear", 1'b1);
        repeat (HOLD + RUN + 4) @(negedge clk);
        chk(eoc_seen == base, "R8 no eoc after abort", eoc_seen - base, 0);
        return;
      end
      if (j < HOLD + RUN && eoc) chk(1'b0, "R5 early eoc", j, HOLD + RUN);
    end
    cmp_in = '0;
    chk(eoc == 1'b1, "R5 eoc at window end", eoc, 1);
    chk(res_valid == 1'b1, "R5 valid with eoc", res_valid, 1);
    check_results(noise ? "R2 R3 counts with hold noise" : "R3 R4 counts", 1'b0);
    @(negedge clk);
    chk(eoc == 1'b0, "R5 eoc single cycle", eoc, 0);
  endtask

  task automatic do_clear;
    clr_in = 1'b1;
    @(negedge clk);
    clr_in = 1'b0;
    chk(res_valid == 1'b0, "R7 valid cleared", res_valid, 0);
    check_results("R7 results cleared", 1'b1);
    chk(busy == 1'b0, "R7 idle after clear", busy, 0);
  endtask

  initial begin
    int dummy;
    int n;
    dummy = $urandom(32'd7331);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0 && eoc == 1'b0 && busy == 1'b0, "R1 reset flags",
        {res_valid, eoc, busy}, 0);
    check_results("R1 reset results", 1'b1);

    // Random run-down lengths, with and without hold noise
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < NCH; i++) lens[i] = $urandom_range(0, RUN + 40);
      run_conv(c[0], -1, $urandom_range(1, 6));
      do_clear();
    end

    // Directed boundary lengths around saturation
    for (int i = 0; i < NCH; i++) begin
      case (i % 6)
        0: lens[i] = 0;
        1: lens[i] = 1;
        2: lens[i] = MAXV - 1;
        3: lens[i] = MAXV;
        4: lens[i] = MAXV + 1;
        default: lens[i] = RUN;
      endcase
    end
    run_conv(1'b1, -1, 1);

    // R6: gates and test requests ignored while results are valid
    n = eoc_seen;
    gate_in = 1'b1;
    repeat (5) @(negedge clk);
    gate_in = 1'b0;
    test_req = 1'b1;
    @(negedge clk);
    test_req = 1'b0;
    repeat (TG + HOLD + RUN + 10) @(negedge clk);
    chk(eoc_seen == n, "R6 no eoc while valid", eoc_seen - n, 0);
    chk(res_valid == 1'b1 && busy == 1'b0, "R6 still valid, not busy",
        {res_valid, busy}, 2);
    check_results("R6 results frozen", 1'b0);

    // R11 + R9: both clears together, gate fully inside lockout is ignored
    fclr_in = 1'b1;
    clr_in  = 1'b1;
    @(negedge clk);
    fclr_in = 1'b0;
    clr_in  = 1'b0;
    chk(res_valid == 1'b0 && busy == 1'b0, "R11 fast clear wins",
        {res_valid, busy}, 0);
    gate_in = 1'b1;
    repeat (SETTLE) @(negedge clk);
    gate_in = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R9 gate in lockout ignored", busy, 0);

    // R9 boundary: gate first seen on the edge just after lockout
    fclr_in = 1'b1;
    @(negedge clk);
    fclr_in = 1'b0;
    repeat (SETTLE) @(negedge clk);
    for (int i = 0; i < NCH; i++) lens[i] = $urandom_range(0, MAXV);
    run_conv(1'b0, -1, 2);
    do_clear();

    // R8: fast clear during hold and mid-window
    run_conv(1'b1, 3, 2);
    repeat (SETTLE) @(negedge clk);
    for (int i = 0; i < NCH; i++) lens[i] = RUN;
    run_conv(1'b0, HOLD + 300, 3);
    repeat (SETTLE) @(negedge clk);

    // R10: internal test gate, exact eoc timing, zero pedestal counts
    for (int i = 0; i < NCH; i++) lens[i] = 0;
    cmp_in = '0;
    test_req = 1'b1;
    @(negedge clk);
    test_req = 1'b0;
    n = 1;
    while (!eoc && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n == TG + HOLD + RUN + 2, "R10 test gate eoc timing", n, TG + HOLD + RUN + 2);
    check_results("R10 test conversion counts", 1'b0);
    do_clear();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule